// File: doc/BRIEF.md
# I2C Slave with Pointer-Addressed Memory Reads

This block is the serial front end of a memory-backed device on a two-wire I2C bus. It watches the SCL and SDA pins through a fast system clock, recognises START, repeated START and STOP, and matches a 7-bit device address. In a write transaction the first data byte is taken as a command and the next bytes load a memory address pointer. The command and the pointer are presented on outputs for the rest of the device.

When the master writes the command and the pointer and then turns the bus around with a repeated START and a read address, the block fetches bytes from a synchronous byte-wide memory port. It streams them out for as long as the master keeps acknowledging, and the pointer advances after every fetch. A read that is not preceded by a pointer write in the same bus session answers differently. It returns a device status word, then the current pointer, most significant byte first in both cases.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After reset SDA is released (`sda_oe_o` = 0), `mem_rd_o` is 0, `cmd_o` is 0x00 and `mem_addr_o` is 0x0000.
- R2: The first byte after a START carries the device address in bits 7..1 and the direction in bit 0 (1 = read). On a match the slave pulls SDA low in the ninth clock. On a mismatch it does not, and it neither acknowledges nor acts on later bytes until the next START, so `cmd_o` and `mem_addr_o` keep their values.
- R3: In a write transaction every byte is acknowledged. The first byte is loaded into `cmd_o`, the next two bytes form the pointer (high byte, then low byte), and the pointer is updated once the low byte arrives. Any bytes after that are acknowledged and discarded.
- R4: A read address after a completed pointer write, with no STOP between them, streams memory bytes starting at the written pointer, one per byte slot. This continues for any number of bytes while the master acknowledges.
- R5: The pointer advances by one in the cycle after each memory read strobe, and it wraps from 0xFFFF to 0x0000.
- R6: A read address with no completed pointer write since the last STOP or write address returns the status high byte, the status low byte, the pointer high byte and the pointer low byte, and then repeats that cycle. The status is sampled when the read address is acknowledged.
- R7: After a not-acknowledge from the master on a read byte the slave releases SDA, and further clock pulses read back 1 until the next START.
- R8: A STOP at any point returns the slave to idle with SDA released. It also cancels read-data mode, so the next read returns the status sequence.
- R9: Apart from a reaction to START or STOP, the SDA drive changes only while the synchronised SCL is low, and it is held steady through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired-AND bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | STATUS_W | Device status word |
| mem_rd_o | output | 1 | One-cycle memory read strobe |
| mem_addr_o | output | PTR_W | Memory address pointer |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the strobe |
| cmd_o | output | 8 | Last command byte received |

## Verification
On every cycle the assertions check that the SDA drive stays steady while SCL is high, that the slave releases the bus when idle and after a STOP, and that a START rearms address reception. They also check that each read strobe lasts one cycle and is followed by a one-step pointer advance, including the wrap. Only the bench scenarios can show the byte-level protocol, because each of these spans hundreds of cycles and depends on earlier transactions. That covers the order of command and pointer bytes, the data stream from the written pointer, the status-then-pointer answer with its latched status, and the silence after a mismatched address or a master NACK.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RXB,
      ST_RACK,
      ST_TXB,
      ST_TACK
   } i2cp_state_e;
endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
   parameter int WIDTH = 2,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= d_i;
   end

   generate
      for (genvar g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= RST_VAL;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cp_cond.sv
module i2cp_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // SDA moving while SCL is held high marks a bus condition
   assign start_o = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
   assign rise_o  = scl_s & ~scl_q;
   assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/i2cp_resp_mux.sv
module i2cp_resp_mux #(
   parameter int STATUS_W = 16,
   parameter int PTR_W = 16,
   parameter int IDX_W = 2
) (
   input  logic [STATUS_W-1:0] status_i,
   input  logic [PTR_W-1:0]    ptr_i,
   input  logic [IDX_W-1:0]    idx_i,
   output logic [7:0]          byte_o
);
   localparam int NB = (STATUS_W + PTR_W) / 8;

   logic [STATUS_W+PTR_W-1:0] cat;
   logic [7:0] lane [NB];

   assign cat = {status_i, ptr_i};

   generate
      for (genvar g = 0; g < NB; g++) begin : g_lane
         assign lane[g] = cat[(NB-1-g)*8 +: 8];
      end
   endgenerate

   always_comb begin
      byte_o = lane[0];
      for (int k = 0; k < NB; k++) begin
         if (idx_i == IDX_W'(k)) byte_o = lane[k];
      end
   end
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
   import i2cp_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h2A,
   parameter int PTR_W = 16,
   parameter int STATUS_W = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_oe_o,
   input  logic [STATUS_W-1:0] status_i,
   output logic                mem_rd_o,
   output logic [PTR_W-1:0]    mem_addr_o,
   input  logic [7:0]          mem_rdata_i,
   output logic [7:0]          cmd_o
);
   localparam int PB = PTR_W / BYTE_W;
   localparam int SB = STATUS_W / BYTE_W;
   localparam int RB = SB + PB;
   localparam int RIDX_W = $clog2(RB);
   localparam int WIDX_W = $clog2(PB + 2);
   localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(PB);
   localparam logic [WIDX_W-1:0] WIDX_SAT = WIDX_W'(PB + 1);
   localparam logic [RIDX_W-1:0] RIDX_END = RIDX_W'(RB - 1);

   generate
      if (PTR_W < 16 || (PTR_W % BYTE_W) != 0) begin : g_chk_ptr
         $error("PTR_W must be a whole number of bytes and at least 16");
      end
      if (STATUS_W < BYTE_W || (STATUS_W % BYTE_W) != 0) begin : g_chk_stat
         $error("STATUS_W must be a whole number of bytes");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // pin synchronisation and bus event detection
   logic [1:0] pins_s;
   logic scl_s, sda_s;
   logic start_w, stop_w, rise_w, fall_w;

   i2cp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (pins_s)
   );
   assign scl_s = pins_s[1];
   assign sda_s = pins_s[0];

   i2cp_cond cond_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s   (scl_s),
      .sda_s   (sda_s),
      .start_o (start_w),
      .stop_o  (stop_w),
      .rise_o  (rise_w),
      .fall_o  (fall_w)
   );

   // controller state
   i2cp_state_e            st_q;
   logic [BIT_CNT_W-1:0]   cnt_q;
   logic [7:0]             rx_q;
   logic [7:0]             tx_q;
   logic                   oe_q;
   logic                   is_addr_q;
   logic                   rd_dir_q;
   logic                   data_mode_q;
   logic                   ptr_set_q;
   logic                   mack_q;
   logic [WIDX_W-1:0]      widx_q;
   logic [RIDX_W-1:0]      ridx_q;
   logic [STATUS_W-1:0]    stat_lat_q;
   logic [PTR_W-1:0]       ptr_snap_q;
   logic [PTR_W-1:0]       ptr_q;
   logic [PTR_W-1:0]       stage_q;
   logic [7:0]             cmd_q;
   logic [7:0]             pf_q;
   logic                   mem_rd_q;
   logic                   fetch_q;

   logic [7:0]             rsp_byte;
   logic [7:0]             next_tx;
   logic [PTR_W-1:0]       stage_nxt;
   logic [RIDX_W-1:0]      ridx_nxt;
   logic                   addr_hit;

   i2cp_resp_mux #(.STATUS_W(STATUS_W), .PTR_W(PTR_W), .IDX_W(RIDX_W)) resp_i (
      .status_i (stat_lat_q),
      .ptr_i    (ptr_snap_q),
      .idx_i    (ridx_q),
      .byte_o   (rsp_byte)
   );

   assign next_tx   = data_mode_q ? pf_q : rsp_byte;
   assign stage_nxt = {stage_q[PTR_W-BYTE_W-1:0], rx_q};
   assign ridx_nxt  = (ridx_q == RIDX_END) ? '0 : ridx_q + 1'b1;
   assign addr_hit  = (rx_q[7:1] == SLAVE_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cnt_q       <= '0;
         rx_q        <= '0;
         tx_q        <= '0;
         oe_q        <= 1'b0;
         is_addr_q   <= 1'b0;
         rd_dir_q    <= 1'b0;
         data_mode_q <= 1'b0;
         ptr_set_q   <= 1'b0;
         mack_q      <= 1'b0;
         widx_q      <= '0;
         ridx_q      <= '0;
         stat_lat_q  <= '0;
         ptr_snap_q  <= '0;
         ptr_q       <= '0;
         stage_q     <= '0;
         cmd_q       <= '0;
         pf_q        <= '0;
         mem_rd_q    <= 1'b0;
         fetch_q     <= 1'b0;
      end else begin
         // memory port: strobe, capture next cycle, advance pointer
         mem_rd_q <= 1'b0;
         fetch_q  <= mem_rd_q;
         if (fetch_q) pf_q <= mem_rdata_i;
         if (mem_rd_q) ptr_q <= ptr_q + 1'b1;

         if (start_w) begin
            st_q      <= ST_RXB;
            cnt_q     <= '0;
            is_addr_q <= 1'b1;
            oe_q      <= 1'b0;
         end else if (stop_w) begin
            st_q      <= ST_IDLE;
            oe_q      <= 1'b0;
            ptr_set_q <= 1'b0;
         end else begin
            case (st_q)
               ST_IDLE: ;

               ST_RXB: begin
                  if (rise_w && cnt_q != 4'd8) begin
                     rx_q  <= {rx_q[6:0], sda_s};
                     cnt_q <= cnt_q + 1'b1;
                  end
                  if (fall_w && cnt_q == 4'd8) begin
                     if (is_addr_q) begin
                        is_addr_q <= 1'b0;
                        if (addr_hit) begin
                           oe_q     <= 1'b1;
                           st_q     <= ST_RACK;
                           rd_dir_q <= rx_q[0];
                           if (rx_q[0]) begin
                              data_mode_q <= ptr_set_q;
                              stat_lat_q  <= status_i;
                              ptr_snap_q  <= ptr_q;
                              ridx_q      <= '0;
                              if (ptr_set_q) mem_rd_q <= 1'b1;
                           end else begin
                              ptr_set_q <= 1'b0;
                              widx_q    <= '0;
                           end
                        end else begin
                           st_q <= ST_IDLE;
                        end
                     end else begin
                        oe_q <= 1'b1;
                        st_q <= ST_RACK;
                        if (widx_q == '0) begin
                           cmd_q <= rx_q;
                        end else if (widx_q <= WIDX_LAST) begin
                           stage_q <= stage_nxt;
                           if (widx_q == WIDX_LAST) begin
                              ptr_q     <= stage_nxt;
                              ptr_set_q <= 1'b1;
                           end
                        end
                        if (widx_q != WIDX_SAT) widx_q <= widx_q + 1'b1;
                     end
                  end
               end

               ST_RACK: begin
                  if (fall_w) begin
                     cnt_q <= '0;
                     if (rd_dir_q) begin
                        st_q <= ST_TXB;
                        tx_q <= next_tx;
                        oe_q <= ~next_tx[7];
                        if (!data_mode_q) ridx_q <= ridx_nxt;
                     end else begin
                        st_q <= ST_RXB;
                        oe_q <= 1'b0;
                     end
                  end
               end

               ST_TXB: begin
                  if (fall_w) begin
                     if (cnt_q == 4'd7) begin
                        oe_q  <= 1'b0;
                        st_q  <= ST_TACK;
                        cnt_q <= '0;
                        if (data_mode_q) mem_rd_q <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                        oe_q  <= ~tx_q[6];
                     end
                  end
               end

               ST_TACK: begin
                  if (rise_w) mack_q <= ~sda_s;
                  if (fall_w) begin
                     if (mack_q) begin
                        st_q <= ST_TXB;
                        tx_q <= next_tx;
                        oe_q <= ~next_tx[7];
                        if (!data_mode_q) ridx_q <= ridx_nxt;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end

               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o   = oe_q;
   assign mem_rd_o   = mem_rd_q;
   assign mem_addr_o = ptr_q;
   assign cmd_o      = cmd_q;
endmodule

// File: rtl/i2cp_chk.sv
module i2cp_chk
   import i2cp_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_w,
   input logic             stop_w,
   input logic             sda_oe_o,
   input logic             mem_rd_o,
   input logic [PTR_W-1:0] mem_addr_o,
   input i2cp_state_e      st_q
);
   AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_w) && !$past(stop_w)) |-> (sda_oe_o == $past(sda_oe_o))); // R9

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !sda_oe_o); // R7

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_w |=> (!sda_oe_o && st_q == ST_IDLE)); // R8

   AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (st_q == ST_RXB && !sda_oe_o)); // R2

   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |=> !mem_rd_o); // R4

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |=> (mem_addr_o == PTR_W'($past(mem_addr_o) + 1'b1))); // R5
endmodule

bind i2c_ptr_slave i2cp_chk #(.PTR_W(PTR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .start_w    (start_w),
   .stop_w     (stop_w),
   .sda_oe_o   (sda_oe_o),
   .mem_rd_o   (mem_rd_o),
   .mem_addr_o (mem_addr_o),
   .st_q       (st_q)
);

// File: tb/i2c_ptr_slave_tb.sv
`timescale 1ns/1ps
module i2c_ptr_slave_tb_top;
   localparam logic [6:0] DEV = 7'h2A;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_oe;
   logic [15:0] status_w = 16'h0000;
   logic mem_rd;
   logic [15:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;
   logic [7:0] cmd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int r9_viol = 0;

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_ptr_slave #(.SLAVE_ADDR(DEV)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_bus),
      .sda_oe_o    (sda_oe),
      .status_i    (status_w),
      .mem_rd_o    (mem_rd),
      .mem_addr_o  (mem_addr),
      .mem_rdata_i (mem_rdata),
      .cmd_o       (cmd)
   );

   function automatic logic [7:0] ref_byte(input logic [15:0] a);
      return a[7:0] + {a[11:8], a[15:12]} + 8'h11;
   endfunction

   // memory model: registered read
   always @(posedge clk) if (mem_rd) mem_rdata <= ref_byte(mem_addr);

   // R9 monitor: slave drive must not move while the raw SCL stays high
   logic scl_prev = 1'b1, oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) r9_viol++;
      scl_prev <= scl_m;
      oe_prev  <= sda_oe;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      @(negedge clk); b = sda_bus;
      wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic write_byte(input logic [7:0] v, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(x);
      ack = ~x;
   endtask

   task automatic read_byte(input logic ack, output logic [7:0] v);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         get_bit(x);
         v[i] = x;
      end
      put_bit(~ack);
   endtask

   task automatic send_cmd_ptr(input logic [7:0] c, input logic [15:0] p);
      logic a;
      bus_start();
      write_byte({DEV, 1'b0}, a); chk(a, "R2 write address ack", a, 1);
      write_byte(c, a);           chk(a, "R3 command ack", a, 1);
      write_byte(p[15:8], a);     chk(a, "R3 pointer high ack", a, 1);
      write_byte(p[7:0], a);      chk(a, "R3 pointer low ack", a, 1);
   endtask

   // vector: {pointer, byte count, command}
   localparam int NV = 4;
   localparam logic [31:0] VEC [NV] = '{
      {16'h1234, 8'd5, 8'hA1},
      {16'hFFFE, 8'd4, 8'h3C},
      {16'h00FF, 8'd3, 8'h07},
      {16'h8000, 8'd2, 8'hE5}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R4 watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d;
      logic [15:0] p;
      logic [7:0] n;
      logic [7:0] c;

      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
      chk(mem_rd == 1'b0, "R1 no read", mem_rd, 0);
      chk(cmd == 8'h00, "R1 command", cmd, 0);
      chk(mem_addr == 16'h0000, "R1 pointer", mem_addr, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);

      // vector walk: pointer write, repeated start, streamed read (R4, R5)
      for (int v = 0; v < NV; v++) begin
         p = VEC[v][31:16];
         n = VEC[v][15:8];
         c = VEC[v][7:0];
         send_cmd_ptr(c, p);
         @(negedge clk);
         chk(cmd == c, "R3 command output", cmd, c);
         bus_start();
         write_byte({DEV, 1'b1}, a); chk(a, "R2 read address ack", a, 1);
         for (int k = 0; k < int'(n); k++) begin
            read_byte(k != int'(n) - 1, d);
            chk(d == ref_byte(p + 16'(k)), "R4/R5 stream byte", d, ref_byte(p + 16'(k)));
         end
         bus_stop();
      end

      // R6: status read with latch check
      send_cmd_ptr(8'h10, 16'h4321);
      bus_stop();
      status_w = 16'hBEEF;
      bus_start();
      write_byte({DEV, 1'b1}, a); chk(a, "R6 read address ack", a, 1);
      read_byte(1'b1, d); chk(d == 8'hBE, "R6 status high", d, 8'hBE);
      status_w = 16'h1111;
      read_byte(1'b1, d); chk(d == 8'hEF, "R6 status low latched", d, 8'hEF);
      read_byte(1'b1, d); chk(d == 8'h43, "R6 pointer high", d, 8'h43);
      read_byte(1'b1, d); chk(d == 8'h21, "R6 pointer low", d, 8'h21);
      read_byte(1'b0, d); chk(d == 8'hBE, "R6 sequence repeats", d, 8'hBE);
      bus_stop();

      // R2: mismatched address is ignored
      bus_start();
      write_byte({DEV ^ 7'h01, 1'b0}, a); chk(!a, "R2 mismatch no ack", a, 0);
      write_byte(8'h55, a); chk(!a, "R2 ignored byte no ack", a, 0);
      write_byte(8'h66, a);
      bus_stop();
      @(negedge clk);
      chk(cmd == 8'h10, "R2 command unchanged", cmd, 8'h10);
      chk(mem_addr == 16'h4321, "R2 pointer unchanged", mem_addr, 16'h4321);

      // R7: master NACK ends the transfer
      send_cmd_ptr(8'h20, 16'h0200);
      bus_start();
      write_byte({DEV, 1'b1}, a);
      read_byte(1'b0, d); chk(d == ref_byte(16'h0200), "R7 single byte", d, ref_byte(16'h0200));
      read_byte(1'b0, d); chk(d == 8'hFF, "R7 bus released after nack", d, 8'hFF);
      bus_stop();

      // R3: extra write bytes are acknowledged and discarded
      send_cmd_ptr(8'h5A, 16'h0ABC);
      write_byte(8'h99, a); chk(a, "R3 extra byte ack", a, 1);
      write_byte(8'h77, a); chk(a, "R3 second extra byte ack", a, 1);
      bus_stop();
      @(negedge clk);
      chk(mem_addr == 16'h0ABC, "R3 pointer kept", mem_addr, 16'h0ABC);
      chk(cmd == 8'h5A, "R3 command kept", cmd, 8'h5A);

      // R8: stop during pointer write cancels read-data mode
      bus_start();
      write_byte({DEV, 1'b0}, a);
      write_byte(8'h33, a);
      write_byte(8'h12, a);
      bus_stop();
      @(negedge clk);
      chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
      chk(mem_addr == 16'h0ABC, "R8 partial pointer not loaded", mem_addr, 16'h0ABC);
      status_w = 16'hC0DE;
      bus_start();
      write_byte({DEV, 1'b1}, a);
      read_byte(1'b0, d); chk(d == 8'hC0, "R8 status after stop", d, 8'hC0);
      bus_stop();

      // R8: stop after a full pointer write also returns status on the next read
      send_cmd_ptr(8'h44, 16'h5566);
      bus_stop();
      bus_start();
      write_byte({DEV, 1'b1}, a);
      read_byte(1'b0, d); chk(d == 8'hC0, "R8 status after completed write and stop", d, 8'hC0);
      bus_stop();

      chk(r9_viol == 0, "R9 drive steady while SCL high", r9_viol, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule